// File: doc/BRIEF.md
# Down-Counting Interval Timer with APB Register Access

This block is a single 32-bit timer that counts down by one on every clock while it is enabled. Software reaches it through an APB slave port: it sets a reload value, picks between a periodic reload and a free-running wrap to all ones, and can mask the interrupt. A level interrupt stays high while an expiry is pending and unmasked. A pending expiry is cleared as a side effect of reading one of two acknowledge locations. One location belongs to the timer and the other sits in a global status group. That group also holds raw and masked status views and a fixed version word.

Elapsed time is the bitwise inverse of the current count. This makes the free-running mode usable as a monotonic time base. The periodic mode gives a fixed interrupt rate.

Top module: `apb_countdown_timer`

## Requirements
- R1: After reset the control field reads 0, the reload value reads 0, the current count reads 0xFFFFFFFF, no expiry is pending and the interrupt output is low.
- R2: The reload value is read/write at offset 0x00. The control field is read/write at offset 0x08, with bit 0 = run, bit 1 = periodic and bit 2 = interrupt mask. Bits above 2 read as 0.
- R3: A write to 0x08 that moves run from 0 to 1 loads the counter with the reload value at that access edge. While run is 1 the counter drops by one per clock. While run is 0 it holds its value.
- R4: When the count is 0 and run is 1, the next clock sets the pending flag and reloads the counter. It reloads the reload value if periodic is 1, and 0xFFFFFFFF if periodic is 0. With a reload value of 0 in periodic mode, the timer expires on every clock.
- R5: While the mask bit is 1, the interrupt output and the masked status (bit 0 at 0x10 and at 0xA0) stay low. The raw status (bit 0 at 0xA8) still shows the pending flag.
- R6: A read of 0x0C returns 0 and clears the pending flag. If an expiry occurs on that same clock, the flag stays set.
- R7: A read of 0xA4 clears the pending flag under the same rules as 0x0C.
- R8: Offset 0xAC reads the constant VERSION parameter. Writes to it are ignored.
- R9: The current count at 0x04 is read-only. Writes to read-only or unmapped offsets change nothing. Reads of unmapped offsets return 0.
- R10: PREADY is always 1 and PSLVERR is always 0.
- R11: A reload-value write while the timer runs does not change the current count. The new value is used at the next reload or the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock for bus and counter |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| tmrIrq | output | 1 | Level interrupt: pending and not masked |

## Verification
The assertions assume a well-formed APB master. Each access has a setup cycle followed by one access cycle, and address, direction and write data are steady across both cycles. So every register side effect is tied to a clock where psel and penable are both high. The stimulus changes bus signals only on falling edges and always runs the two phases in order, one transfer at a time. Reload values in the random phase stay small, so periodic expiries, acknowledges that collide with an expiry, and mask changes all occur many times within the run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Register offsets; the map is fixed by software that drives this block.
  localparam logic [7:0] OFF_LOAD  = 8'h00;
  localparam logic [7:0] OFF_CUR   = 8'h04;
  localparam logic [7:0] OFF_CTRL  = 8'h08;
  localparam logic [7:0] OFF_EOI   = 8'h0C;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_GSTAT = 8'hA0;
  localparam logic [7:0] OFF_GEOI  = 8'hA4;
  localparam logic [7:0] OFF_GRAW  = 8'hA8;
  localparam logic [7:0] OFF_VER   = 8'hAC;

  // Control field bit positions.
  localparam int CTL_RUN  = 0;
  localparam int CTL_PER  = 1;
  localparam int CTL_MASK = 2;
  localparam int CTL_W    = 3;

  // Strobes from register control to the counting datapath.
  typedef struct packed {
    logic start;   // run bit rising: load counter from reload value
    logic ackClr;  // acknowledge read: clear pending flag
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 32,
  parameter logic [DATA_W-1:0] VERSION = 32'h3230_312A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              pendRaw,
  output logic [DATA_W-1:0] prdata,
  output logic [CNT_W-1:0]  loadVal,
  output logic              enable,
  output logic              periodic,
  output logic              intMask,
  output tmrStrobe_t        strobe
);
  logic             accessPhase;
  logic             wrAcc;
  logic             rdAcc;
  logic [CTL_W-1:0] ctrlQ;
  logic [CNT_W-1:0] loadQ;
  logic             maskedStat;

  assign accessPhase = psel && penable;
  assign wrAcc = accessPhase && pwrite;
  assign rdAcc = accessPhase && !pwrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ <= '0;
      ctrlQ <= '0;
    end else if (wrAcc) begin
      if (paddr == ADDR_W'(OFF_LOAD)) loadQ <= pwdata[CNT_W-1:0];
      if (paddr == ADDR_W'(OFF_CTRL)) ctrlQ <= pwdata[CTL_W-1:0];
    end
  end

  assign loadVal  = loadQ;
  assign enable   = ctrlQ[CTL_RUN];
  assign periodic = ctrlQ[CTL_PER];
  assign intMask  = ctrlQ[CTL_MASK];

  always_comb begin
    strobe = '0;
    strobe.start  = wrAcc && (paddr == ADDR_W'(OFF_CTRL))
                    && pwdata[CTL_RUN] && !ctrlQ[CTL_RUN];
    strobe.ackClr = rdAcc && ((paddr == ADDR_W'(OFF_EOI))
                    || (paddr == ADDR_W'(OFF_GEOI)));
  end

  assign maskedStat = pendRaw && !ctrlQ[CTL_MASK];

  always_comb begin
    prdata = '0;
    if (rdAcc) begin
      case (paddr)
        ADDR_W'(OFF_LOAD):  prdata = DATA_W'(loadQ);
        ADDR_W'(OFF_CUR):   prdata = DATA_W'(cntVal);
        ADDR_W'(OFF_CTRL):  prdata = DATA_W'(ctrlQ);
        ADDR_W'(OFF_STAT):  prdata = DATA_W'(maskedStat);
        ADDR_W'(OFF_GSTAT): prdata = DATA_W'(maskedStat);
        ADDR_W'(OFF_GRAW):  prdata = DATA_W'(pendRaw);
        ADDR_W'(OFF_VER):   prdata = VERSION;
        default:            prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  input  logic             enable,
  input  logic             periodic,
  input  logic             intMask,
  output logic [CNT_W-1:0] cntVal,
  output logic             pendRaw,
  output logic             irq
);
  localparam logic [CNT_W-1:0] WRAP_VAL = '1;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] reloadVal;
  logic             pendQ;
  logic             expire;

  assign expire    = enable && (cntQ == '0);
  assign reloadVal = periodic ? loadVal : WRAP_VAL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= WRAP_VAL;
    end else if (strobe.start) begin
      cntQ <= loadVal;
    end else if (expire) begin
      cntQ <= reloadVal;
    end else if (enable) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  // Expiry wins over an acknowledge in the same clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (expire) begin
      pendQ <= 1'b1;
    end else if (strobe.ackClr) begin
      pendQ <= 1'b0;
    end
  end

  assign cntVal  = cntQ;
  assign pendRaw = pendQ;
  assign irq     = pendQ && !intMask;
endmodule

// File: rtl/apb_countdown_timer.sv
module apb_countdown_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 32,
  parameter logic [DATA_W-1:0] VERSION = 32'h3230_312A
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              tmrIrq
);
  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] loadVal;
  logic             pendRaw;
  logic             enable;
  logic             periodic;
  logic             intMask;

  tmr_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .VERSION(VERSION)
  ) u_ctl (
    .clk(pclk), .rstN(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .cntVal(cntVal),
    .pendRaw(pendRaw), .prdata(prdata), .loadVal(loadVal), .enable(enable),
    .periodic(periodic), .intMask(intMask), .strobe(strobe)
  );

  tmr_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(pclk), .rstN(presetn), .strobe(strobe), .loadVal(loadVal),
    .enable(enable), .periodic(periodic), .intMask(intMask),
    .cntVal(cntVal), .pendRaw(pendRaw), .irq(tmrIrq)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 32,
  parameter logic [DATA_W-1:0] VERSION = 32'h3230_312A
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic              tmrIrq,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  loadVal,
  input logic              pendRaw,
  input logic              enable,
  input logic              periodic,
  input logic              intMask
);
  logic rdAcc;
  logic startEv;
  logic atZero;

  assign rdAcc   = psel && penable && !pwrite;
  assign startEv = psel && penable && pwrite && (paddr == ADDR_W'(OFF_CTRL))
                   && pwdata[CTL_RUN] && !enable;
  assign atZero  = enable && (cntVal == '0);

  AST_START_LOAD: assert property (@(posedge pclk) disable iff (!presetn)
    startEv |=> cntVal == $past(loadVal)); // R3
  AST_COUNT_DOWN: assert property (@(posedge pclk) disable iff (!presetn)
    (enable && cntVal != '0) |=> cntVal == $past(cntVal) - CNT_W'(1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge pclk) disable iff (!presetn)
    (!enable && !startEv) |=> $stable(cntVal)); // R3
  AST_RELOAD_PERIODIC: assert property (@(posedge pclk) disable iff (!presetn)
    (atZero && periodic) |=> (cntVal == $past(loadVal)) && pendRaw); // R4
  AST_RELOAD_WRAP: assert property (@(posedge pclk) disable iff (!presetn)
    (atZero && !periodic) |=> (cntVal == '1) && pendRaw); // R4
  AST_MASK_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    intMask |-> !tmrIrq); // R5
  AST_ACK_CLEAR: assert property (@(posedge pclk) disable iff (!presetn)
    (rdAcc && paddr == ADDR_W'(OFF_EOI) && !atZero) |=> !pendRaw); // R6
  AST_GACK_CLEAR: assert property (@(posedge pclk) disable iff (!presetn)
    (rdAcc && paddr == ADDR_W'(OFF_GEOI) && !atZero) |=> !pendRaw); // R7
  AST_VERSION_READ: assert property (@(posedge pclk) disable iff (!presetn)
    (rdAcc && paddr == ADDR_W'(OFF_VER)) |-> prdata == VERSION); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (rdAcc && paddr > ADDR_W'(OFF_VER)) |-> prdata == '0); // R9
  AST_BUS_OK: assert property (@(posedge pclk) disable iff (!presetn)
    psel |-> (pready && !pslverr)); // R10
endmodule

bind apb_countdown_timer tmr_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .VERSION(VERSION)
) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .pready(pready), .pslverr(pslverr), .tmrIrq(tmrIrq), .cntVal(cntVal),
  .loadVal(loadVal), .pendRaw(pendRaw), .enable(enable),
  .periodic(periodic), .intMask(intMask)
);

// File: tb/apb_countdown_timer_tb.sv
module apb_countdown_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VER = 32'h3230_312A;

  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, tmrIrq;

  int checks = 0;
  int errors = 0;

  // Reference state computed from the requirements.
  logic [31:0] mCnt = 32'hFFFF_FFFF;
  logic [31:0] mLoad = '0;
  logic [2:0]  mCtl = '0;
  logic        mPend = 1'b0;

  always #(CLK_PERIOD/2) pclk = ~pclk;

  apb_countdown_timer u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .tmrIrq(tmrIrq)
  );

  always @(posedge pclk) begin
    if (!presetn) begin
      mCnt = 32'hFFFF_FFFF; mLoad = '0; mCtl = '0; mPend = 1'b0;
    end else begin
      logic acc, en, hit0, start, ack;
      acc   = psel && penable;
      en    = mCtl[0];
      hit0  = en && (mCnt == 32'd0);
      start = acc && pwrite && paddr == 8'h08 && pwdata[0] && !en;
      ack   = acc && !pwrite && (paddr == 8'h0C || paddr == 8'hA4);
      if (start) mCnt = mLoad;
      else if (hit0) mCnt = mCtl[1] ? mLoad : 32'hFFFF_FFFF;
      else if (en) mCnt = mCnt - 32'd1;
      if (hit0) mPend = 1'b1;
      else if (ack) mPend = 1'b0;
      if (acc && pwrite && paddr == 8'h00) mLoad = pwdata;
      if (acc && pwrite && paddr == 8'h08) mCtl = pwdata[2:0];
    end
  end

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00: return mLoad;
      8'h04: return mCnt;
      8'h08: return {29'd0, mCtl};
      8'h10, 8'hA0: return {31'd0, mPend && !mCtl[2]};
      8'hA8: return {31'd0, mPend};
      8'hAC: return VER;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(input logic [7:0] a);
    case (a)
      8'h00, 8'h08: return "R2";
      8'h04: return "R3";
      8'h0C: return "R6";
      8'hA4: return "R7";
      8'h10, 8'hA0, 8'hA8: return "R5";
      8'hAC: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [7:0] a, input string tag);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    check(prdata, expRead(a), tag);
    check({31'd0, pready && !pslverr}, 32'd1, "R10");
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // Interrupt level versus reference every cycle.
  always @(negedge pclk) begin
    if (presetn) check({31'd0, tmrIrq}, {31'd0, mPend && !mCtl[2]}, "R5 irq");
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    // R1 reset state
    apbRead(8'h00, "R1"); apbRead(8'h08, "R1"); apbRead(8'h04, "R1");
    apbRead(8'hA8, "R1"); apbRead(8'h10, "R1");
    check({31'd0, tmrIrq}, 32'd0, "R1 irq");
    // R8 version constant, write ignored
    apbRead(8'hAC, "R8");
    apbWrite(8'hAC, 32'h0);
    apbRead(8'hAC, "R8");
    // R9 read-only and unmapped
    apbWrite(8'h04, 32'h1234);
    apbRead(8'h04, "R9");
    check(expRead(8'h04), 32'hFFFF_FFFF, "R9 model");
    apbWrite(8'h50, 32'hFFFF_FFFF);
    apbRead(8'h50, "R9"); apbRead(8'h14, "R9"); apbRead(8'hB0, "R9");
    apbRead(8'h08, "R9"); apbRead(8'h00, "R9");
    // R4 zero reload in periodic mode expires every clock
    apbWrite(8'h00, 32'd0);
    apbWrite(8'h08, 32'h3);
    apbRead(8'hA8, "R4");
    apbRead(8'h0C, "R6");
    apbRead(8'hA8, "R6 expiry wins");
    check(expRead(8'hA8), 32'd1, "R6 model");
    // R5 mask
    apbWrite(8'h08, 32'h7);
    apbRead(8'h10, "R5"); apbRead(8'hA0, "R5"); apbRead(8'hA8, "R5");
    // R7 global acknowledge after stopping
    apbWrite(8'h08, 32'h0);
    apbRead(8'hA4, "R7");
    apbRead(8'hA8, "R7");
    check(expRead(8'hA8), 32'd0, "R7 model");
    // R3/R4 periodic run
    apbWrite(8'h00, 32'd5);
    apbWrite(8'h08, 32'h3);
    for (int i = 0; i < 8; i++) apbRead(8'h04, "R3");
    apbRead(8'h10, "R4");
    // R11 reload write while running
    apbWrite(8'h00, 32'd20);
    apbRead(8'h04, "R11");
    check({31'd0, mCnt <= 32'd6}, 32'd1, "R11 model");
    repeat (10) apbRead(8'h04, "R11");
    // R4 free-running wrap
    apbWrite(8'h08, 32'h0);
    apbWrite(8'h00, 32'd3);
    apbWrite(8'h08, 32'h1);
    repeat (6) @(negedge pclk);
    apbRead(8'h04, "R4");
    check({31'd0, mCnt > 32'hFFFF_0000}, 32'd1, "R4 wrap model");
    apbRead(8'hA8, "R4");
    apbRead(8'h0C, "R6");
    apbRead(8'hA8, "R6");
    // Random phase
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [7:0] addrs [11];
      addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'hA0, 8'hA4, 8'hA8, 8'hAC, 8'h14, 8'hB0};
      op = int'($urandom % 8);
      case (op)
        0: apbWrite(8'h00, $urandom % 40);
        1: apbWrite(8'h08, $urandom % 8);
        6: apbWrite(addrs[1 + ($urandom % 10)], $urandom);
        7: repeat (1 + ($urandom % 6)) @(negedge pclk);
        default: begin
          logic [7:0] a;
          a = addrs[$urandom % 11];
          apbRead(a, tagOf(a));
        end
      endcase
    end
    repeat (2) @(negedge pclk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule